// File: doc/BRIEF.md
# Systolic Tile Multiply-Accumulate Element

This block is one cell of a two-dimensional systolic array for matrix products. It takes in a square tile of the left operand A and a square tile of the right operand B. Each tile arrives one row per beat, in row-major order. The cell multiplies the tile pair and adds the product into a local result tile. A product can span several tile pairs: the A tiles come from one row of tiles and the B tiles from one column of tiles. Once the programmed number of pairs has been reduced, the finished result tile is streamed out row by row.

Every A tile the cell takes in is passed on unchanged to the right-hand neighbour. Every B tile is passed on to the neighbour below. Both operand inputs have two banks, so a new tile can be loaded while the other bank is being multiplied and forwarded. The result store also has two banks: one accumulates while the other drains. Arithmetic is signed two's-complement integer, so no arithmetic IP is needed. Each step computes one result element as an N-term dot product and adds it to that element's partial sum.

Top module: `pe_tile_mac`

## Requirements
- R1: While reset is held, and in the cycle after it, `a_out_valid`, `b_out_valid` and `c_out_valid` are low, and `a_in_ready` and `b_in_ready` are high.
- R2: An operand beat carries one tile row of N signed DW-bit elements, with column k at bits [k*DW +: DW]. A tile is N beats, rows 0 to N-1 in order. A result beat carries one row of N AW-bit elements, with column j at bits [j*AW +: AW].
- R3: The k-th A tile is paired with the k-th B tile. Each result element (i,j) equals the sum, over the pairs of one product, of the sum over k of A[i][k]*B[k][j], wrapped to AW bits. The first pair of a product overwrites the stored partial sum and does not add to it.
- R4: `tile_cnt` sets the number of tile pairs reduced into one result. A value of 0 is treated as 1. `tile_cnt` must only change while no product is in progress.
- R5: Every A tile accepted is sent on `a_out` exactly once, unchanged and in arrival order. Data stays stable while `a_out_valid` is high and `a_out_ready` is low.
- R6: Every B tile accepted is sent on `b_out` exactly once, unchanged and in arrival order, with the same hold rule as A.
- R7: A result leaves as N beats, row 0 first. `c_out_last` is high only on row N-1. Data and last stay stable while `c_out_ready` is low.
- R8: Each operand side holds at most two tiles. With forwarding blocked from reset, exactly 2N beats are accepted on each input.
- R9: If a product completes while the previous result has not yet drained, accumulation halts without loss. The undrained result keeps being presented, and all results later drain in order.
- R10: An input bank is reused only after its tile has been both multiplied and forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tile_cnt | input | CW | Tile pairs per result (0 means 1) |
| a_in_valid | input | 1 | A row offered |
| a_in_ready | output | 1 | A row accepted |
| a_in_data | input | N*DW | A tile row |
| b_in_valid | input | 1 | B row offered |
| b_in_ready | output | 1 | B row accepted |
| b_in_data | input | N*DW | B tile row |
| a_out_valid | output | 1 | Forwarded A row offered to the right |
| a_out_ready | input | 1 | Right neighbour takes A row |
| a_out_data | output | N*DW | Forwarded A row |
| b_out_valid | output | 1 | Forwarded B row offered downward |
| b_out_ready | input | 1 | Lower neighbour takes B row |
| b_out_data | output | N*DW | Forwarded B row |
| c_out_valid | output | 1 | Result row offered |
| c_out_ready | input | 1 | Result row taken |
| c_out_data | output | N*AW | Result row |
| c_out_last | output | 1 | Final row of a result tile |

## Verification
The hardest case to reach is the one where a whole result bank is still waiting to drain when the next product finishes. In that state the accumulator must freeze while the operand banks refill behind it. To reach it, the stimulus holds `c_out_ready` low for hundreds of cycles while five single-pair products are streamed in. It then checks that the first row stays on the port and that exactly four tiles were taken on the A side. A separate phase blocks both forwarding outputs from reset to show that the input banks are kept after their tiles have been multiplied. Random backpressure on all three outputs, together with products of one, two and three pairs and a zero count, covers the remaining orderings.

// File: rtl/pe_pkg.sv
// Shared defaults and types for the tile multiply-accumulate element.
// Assumes nothing beyond a synthesizable SystemVerilog flow.
package pe_pkg;
    localparam int unsigned DEF_EDGE = 32;   // tile edge
    localparam int unsigned DEF_DW   = 8;    // operand element width
    localparam int unsigned DEF_AW   = 32;   // accumulator element width
    localparam int unsigned DEF_CW   = 8;    // tile pair count width

    // Accumulator phase: running, or holding a finished tile for swap.
    typedef enum logic {
        ACC_RUN  = 1'b0,
        ACC_HOLD = 1'b1
    } acc_phase_e;
endpackage

// File: rtl/pe_tile_buf.sv
// Two-bank operand tile buffer.
// Loads a tile one row per beat into the free bank, exposes the oldest
// unconsumed bank to the compute engine, and forwards tiles in order on an
// output stream. A bank is freed only after it was both consumed and
// forwarded. Assumes cmp_done is pulsed only while cmp_full is high.
module pe_tile_buf #(
    parameter int N = 32,
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [N*W-1:0]   in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [N*W-1:0]   out_data,
    output logic             cmp_full,
    output logic [N*W-1:0]   cmp_rows [N],
    input  logic             cmp_done
);
    localparam int RW = (N > 1) ? $clog2(N) : 1;
    localparam logic [RW-1:0] LAST_ROW = RW'(N - 1);

    logic [N*W-1:0] mem [2][N];
    logic [1:0]     full, used, sent;
    logic           ld_sel, cmp_sel, fw_sel;
    logic [RW-1:0]  ld_row, fw_row;
    logic           ld_hs, fw_hs;

    assign in_ready  = !full[ld_sel];
    assign ld_hs     = in_valid && in_ready;
    assign out_valid = full[fw_sel] && !sent[fw_sel];
    assign out_data  = mem[fw_sel][fw_row];
    assign fw_hs     = out_valid && out_ready;
    assign cmp_full  = full[cmp_sel] && !used[cmp_sel];

    // Present every row of the bank under computation.
    always_comb begin
        for (int r = 0; r < N; r++) begin
            cmp_rows[r] = mem[cmp_sel][r];
        end
    end

    // Store incoming rows into the loading bank.
    always_ff @(posedge clk) begin
        if (ld_hs) begin
            mem[ld_sel][ld_row] <= in_data;
        end
    end

    // Track bank occupancy, compute ownership and forwarding progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full    <= '0;
            used    <= '0;
            sent    <= '0;
            ld_sel  <= 1'b0;
            cmp_sel <= 1'b0;
            fw_sel  <= 1'b0;
            ld_row  <= '0;
            fw_row  <= '0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (full[b] && used[b] && sent[b]) begin
                    full[b] <= 1'b0;
                    used[b] <= 1'b0;
                    sent[b] <= 1'b0;
                end
            end
            if (ld_hs) begin
                if (ld_row == LAST_ROW) begin
                    ld_row       <= '0;
                    full[ld_sel] <= 1'b1;
                    ld_sel       <= ~ld_sel;
                end else begin
                    ld_row <= ld_row + RW'(1);
                end
            end
            if (cmp_done) begin
                used[cmp_sel] <= 1'b1;
                cmp_sel       <= ~cmp_sel;
            end
            if (fw_hs) begin
                if (fw_row == LAST_ROW) begin
                    fw_row       <= '0;
                    sent[fw_sel] <= 1'b1;
                    fw_sel       <= ~fw_sel;
                end else begin
                    fw_row <= fw_row + RW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pe_mac_core.sv
// Multiply-accumulate sequencer.
// Computes one result element per cycle as an N-term signed dot product of
// an A row and a B column, and adds it to the stored partial sum (or
// overwrites it on the first pair of a product). After the last pair it
// holds until the result store accepts the finished tile.
// Assumes tile_cnt is stable while a product is in progress.
module pe_mac_core
    import pe_pkg::*;
#(
    parameter int N  = 32,
    parameter int DW = 8,
    parameter int AW = 32,
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        tile_cnt,
    input  logic                 a_full,
    input  logic [N*DW-1:0]      a_rows [N],
    input  logic                 b_full,
    input  logic [N*DW-1:0]      b_rows [N],
    output logic                 pair_done,
    output logic                 wr_en,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] wr_i,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] wr_j,
    output logic [AW-1:0]        wr_data,
    input  logic [AW-1:0]        acc_rd_data,
    output logic                 fin_req,
    input  logic                 fin_ack
);
    localparam int RW = (N > 1) ? $clog2(N) : 1;
    localparam logic [RW-1:0] LAST_IDX = RW'(N - 1);

    acc_phase_e          phase;
    logic [RW-1:0]       row_i, col_j;
    logic [CW-1:0]       pair_cnt, tc_eff;
    logic                run, tile_end, last_pair;
    logic signed [AW-1:0]     dot;
    logic signed [DW-1:0]     av, bv;
    logic signed [2*DW-1:0]   prod;

    assign tc_eff    = (tile_cnt == '0) ? CW'(1) : tile_cnt;
    assign last_pair = (pair_cnt >= tc_eff - CW'(1));
    assign fin_req   = (phase == ACC_HOLD);
    assign run       = a_full && b_full && (phase == ACC_RUN);
    assign tile_end  = run && (row_i == LAST_IDX) && (col_j == LAST_IDX);
    assign pair_done = tile_end;
    assign wr_en     = run;
    assign wr_i      = row_i;
    assign wr_j      = col_j;

    // Dot product of A row row_i with B column col_j.
    always_comb begin
        dot  = '0;
        av   = '0;
        bv   = '0;
        prod = '0;
        for (int k = 0; k < N; k++) begin
            av   = a_rows[row_i][k*DW +: DW];
            bv   = b_rows[k][col_j*DW +: DW];
            prod = av * bv;
            dot  = dot + AW'(prod);
        end
    end

    // First pair overwrites, later pairs add to the partial sum.
    assign wr_data = ((pair_cnt == '0) ? '0 : acc_rd_data) + dot;

    // Walk the result tile, count pairs and hand off finished tiles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= ACC_RUN;
            row_i    <= '0;
            col_j    <= '0;
            pair_cnt <= '0;
        end else begin
            if (run) begin
                if (col_j == LAST_IDX) begin
                    col_j <= '0;
                    if (row_i == LAST_IDX) begin
                        row_i <= '0;
                    end else begin
                        row_i <= row_i + RW'(1);
                    end
                end else begin
                    col_j <= col_j + RW'(1);
                end
            end
            if (tile_end) begin
                if (last_pair) begin
                    pair_cnt <= '0;
                    phase    <= ACC_HOLD;
                end else begin
                    pair_cnt <= pair_cnt + CW'(1);
                end
            end
            if (fin_req && fin_ack) begin
                phase <= ACC_RUN;
            end
        end
    end
endmodule

// File: rtl/pe_result_store.sv
// Two-bank result tile store.
// One bank takes read-modify-write traffic from the sequencer while the
// other drains row by row on a valid/ready stream. A finished tile is
// swapped in only when the drain bank is empty.
// Assumes writes address the accumulating bank only.
module pe_result_store #(
    parameter int N  = 32,
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [((N > 1) ? $clog2(N) : 1)-1:0] wr_i,
    input  logic [((N > 1) ? $clog2(N) : 1)-1:0] wr_j,
    input  logic [AW-1:0]        wr_data,
    output logic [AW-1:0]        rd_data,
    input  logic                 fin_req,
    output logic                 fin_ack,
    output logic                 c_valid,
    input  logic                 c_ready,
    output logic [N*AW-1:0]      c_data,
    output logic                 c_last
);
    localparam int RW = (N > 1) ? $clog2(N) : 1;
    localparam logic [RW-1:0] LAST_ROW = RW'(N - 1);

    logic [AW-1:0]  acc [2][N][N];
    logic           acc_sel, drn_sel, drn_full;
    logic [RW-1:0]  drn_row;
    logic           c_hs;

    assign drn_sel = ~acc_sel;
    assign rd_data = acc[acc_sel][wr_i][wr_j];
    assign fin_ack = fin_req && !drn_full;
    assign c_valid = drn_full;
    assign c_last  = drn_full && (drn_row == LAST_ROW);
    assign c_hs    = c_valid && c_ready;

    // Assemble the current drain row.
    always_comb begin
        for (int j = 0; j < N; j++) begin
            c_data[j*AW +: AW] = acc[drn_sel][drn_row][j];
        end
    end

    // Write accumulated elements into the active bank.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            acc[acc_sel][wr_i][wr_j] <= wr_data;
        end
    end

    // Swap banks on hand-off and step through drain rows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_sel  <= 1'b0;
            drn_full <= 1'b0;
            drn_row  <= '0;
        end else begin
            if (fin_ack) begin
                acc_sel  <= ~acc_sel;
                drn_full <= 1'b1;
                drn_row  <= '0;
            end
            if (c_hs) begin
                if (drn_row == LAST_ROW) begin
                    drn_full <= 1'b0;
                    drn_row  <= '0;
                end else begin
                    drn_row <= drn_row + RW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pe_tile_mac.sv
// Systolic processing element: tile multiply-accumulate with operand
// forwarding. A tiles pass right, B tiles pass down, results drain on the
// c_out stream. Assumes tile_cnt changes only between products.
module pe_tile_mac
    import pe_pkg::*;
#(
    parameter int N  = DEF_EDGE,
    parameter int DW = DEF_DW,
    parameter int AW = DEF_AW,
    parameter int CW = DEF_CW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    tile_cnt,
    input  logic             a_in_valid,
    output logic             a_in_ready,
    input  logic [N*DW-1:0]  a_in_data,
    input  logic             b_in_valid,
    output logic             b_in_ready,
    input  logic [N*DW-1:0]  b_in_data,
    output logic             a_out_valid,
    input  logic             a_out_ready,
    output logic [N*DW-1:0]  a_out_data,
    output logic             b_out_valid,
    input  logic             b_out_ready,
    output logic [N*DW-1:0]  b_out_data,
    output logic             c_out_valid,
    input  logic             c_out_ready,
    output logic [N*AW-1:0]  c_out_data,
    output logic             c_out_last
);
    localparam int RW = (N > 1) ? $clog2(N) : 1;

    logic             a_full, b_full, pair_done;
    logic [N*DW-1:0]  a_rows [N];
    logic [N*DW-1:0]  b_rows [N];
    logic             wr_en, fin_req, fin_ack;
    logic [RW-1:0]    wr_i, wr_j;
    logic [AW-1:0]    wr_data, acc_rd_data;

    pe_tile_buf #(.N(N), .W(DW)) i_abuf (
        .clk(clk), .rst_n(rst_n),
        .in_valid(a_in_valid), .in_ready(a_in_ready), .in_data(a_in_data),
        .out_valid(a_out_valid), .out_ready(a_out_ready), .out_data(a_out_data),
        .cmp_full(a_full), .cmp_rows(a_rows), .cmp_done(pair_done)
    );

    pe_tile_buf #(.N(N), .W(DW)) i_bbuf (
        .clk(clk), .rst_n(rst_n),
        .in_valid(b_in_valid), .in_ready(b_in_ready), .in_data(b_in_data),
        .out_valid(b_out_valid), .out_ready(b_out_ready), .out_data(b_out_data),
        .cmp_full(b_full), .cmp_rows(b_rows), .cmp_done(pair_done)
    );

    pe_mac_core #(.N(N), .DW(DW), .AW(AW), .CW(CW)) i_core (
        .clk(clk), .rst_n(rst_n), .tile_cnt(tile_cnt),
        .a_full(a_full), .a_rows(a_rows), .b_full(b_full), .b_rows(b_rows),
        .pair_done(pair_done), .wr_en(wr_en), .wr_i(wr_i), .wr_j(wr_j),
        .wr_data(wr_data), .acc_rd_data(acc_rd_data),
        .fin_req(fin_req), .fin_ack(fin_ack)
    );

    pe_result_store #(.N(N), .AW(AW)) i_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_i(wr_i), .wr_j(wr_j), .wr_data(wr_data),
        .rd_data(acc_rd_data), .fin_req(fin_req), .fin_ack(fin_ack),
        .c_valid(c_out_valid), .c_ready(c_out_ready),
        .c_data(c_out_data), .c_last(c_out_last)
    );
endmodule

// File: rtl/pe_tile_mac_chk.sv
// Port-level protocol checker for pe_tile_mac, attached by bind.
// Assumes the synchronous active-low reset of the element.
module pe_tile_mac_chk #(
    parameter int N  = 32,
    parameter int DW = 8,
    parameter int AW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_in_valid,
    input logic             a_in_ready,
    input logic             b_in_ready,
    input logic             a_out_valid,
    input logic             a_out_ready,
    input logic [N*DW-1:0]  a_out_data,
    input logic             b_out_valid,
    input logic             b_out_ready,
    input logic [N*DW-1:0]  b_out_data,
    input logic             c_out_valid,
    input logic             c_out_ready,
    input logic [N*AW-1:0]  c_out_data,
    input logic             c_out_last
);
    localparam int RW = (N > 1) ? $clog2(N) : 1;

    logic [RW-1:0] c_beat;
    int            a_occ;

    // Count result beats within a tile and A rows held inside the element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_beat <= '0;
            a_occ  <= 0;
        end else begin
            if (c_out_valid && c_out_ready) begin
                c_beat <= (c_beat == RW'(N - 1)) ? '0 : c_beat + RW'(1);
            end
            a_occ <= a_occ + ((a_in_valid && a_in_ready) ? 1 : 0)
                           - ((a_out_valid && a_out_ready) ? 1 : 0);
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!a_out_valid && !b_out_valid && !c_out_valid && a_in_ready && b_in_ready));

    p_a_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_out_valid && !a_out_ready) |=> (a_out_valid && $stable(a_out_data)));

    p_b_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_out_valid && !b_out_ready) |=> (b_out_valid && $stable(b_out_data)));

    p_c_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_out_valid && !c_out_ready) |=> (c_out_valid && $stable(c_out_data) && $stable(c_out_last)));

    p_last_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_out_valid |-> (c_out_last == (c_beat == RW'(N - 1))));

    p_a_occupancy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_occ >= 0) && (a_occ <= 2 * N));
endmodule

bind pe_tile_mac pe_tile_mac_chk #(.N(N), .DW(DW), .AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .a_in_valid(a_in_valid), .a_in_ready(a_in_ready), .b_in_ready(b_in_ready),
    .a_out_valid(a_out_valid), .a_out_ready(a_out_ready), .a_out_data(a_out_data),
    .b_out_valid(b_out_valid), .b_out_ready(b_out_ready), .b_out_data(b_out_data),
    .c_out_valid(c_out_valid), .c_out_ready(c_out_ready), .c_out_data(c_out_data),
    .c_out_last(c_out_last)
);

// File: tb/test_pe_tile_mac.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural tile-product model with queues,
// random valid and backpressure, compared on every handshake.
module test_pe_tile_mac;
    localparam int N   = 4;
    localparam int DW  = 8;
    localparam int AW  = 32;
    localparam int CW  = 8;
    localparam int ORW = N * DW;
    localparam int CRW = N * AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0]  tile_cnt = '0;
    logic a_in_valid, a_in_ready, b_in_valid, b_in_ready;
    logic [ORW-1:0] a_in_data, b_in_data, a_out_data, b_out_data;
    logic a_out_valid, a_out_ready, b_out_valid, b_out_ready;
    logic c_out_valid, c_out_ready, c_out_last;
    logic [CRW-1:0] c_out_data;

    logic [ORW-1:0] a_src[$], b_src[$], a_exp[$], b_exp[$];
    logic [CRW-1:0] c_exp[$];

    int rdy_a_pct = 100, rdy_b_pct = 100, rdy_c_pct = 100, val_pct = 100;
    int checks = 0, errors = 0, drv_checks = 0, drv_errors = 0;
    int a_acc_beats = 0, b_acc_beats = 0, c_seen = 0, c_row_idx = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    pe_tile_mac #(.N(N), .DW(DW), .AW(AW), .CW(CW)) i_pe_tile_mac (
        .clk(clk), .rst_n(rst_n), .tile_cnt(tile_cnt),
        .a_in_valid(a_in_valid), .a_in_ready(a_in_ready), .a_in_data(a_in_data),
        .b_in_valid(b_in_valid), .b_in_ready(b_in_ready), .b_in_data(b_in_data),
        .a_out_valid(a_out_valid), .a_out_ready(a_out_ready), .a_out_data(a_out_data),
        .b_out_valid(b_out_valid), .b_out_ready(b_out_ready), .b_out_data(b_out_data),
        .c_out_valid(c_out_valid), .c_out_ready(c_out_ready),
        .c_out_data(c_out_data), .c_out_last(c_out_last)
    );

    // Check used by the main sequence only.
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [CRW-1:0] act, input logic [CRW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Check used by the stream driver only.
    task automatic dchk(input bit ok, input string req, input string what,
                        input logic [CRW-1:0] act, input logic [CRW-1:0] exp);
        drv_checks++;
        if (!ok) begin
            drv_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Stream driver and scoreboard: drive at negedge, judge handshakes.
    always begin
        @(negedge clk);
        if (!rst_n) begin
            a_in_valid = 1'b0; b_in_valid = 1'b0;
            a_in_data = '0; b_in_data = '0;
            a_out_ready = 1'b0; b_out_ready = 1'b0; c_out_ready = 1'b0;
        end else begin
            a_out_ready = ($urandom_range(99) < rdy_a_pct);
            b_out_ready = ($urandom_range(99) < rdy_b_pct);
            c_out_ready = ($urandom_range(99) < rdy_c_pct);
            a_in_valid  = (a_src.size() > 0) && ($urandom_range(99) < val_pct);
            b_in_valid  = (b_src.size() > 0) && ($urandom_range(99) < val_pct);
            a_in_data   = (a_src.size() > 0) ? a_src[0] : '0;
            b_in_data   = (b_src.size() > 0) ? b_src[0] : '0;
            #1;
            if (a_in_valid && a_in_ready) begin
                a_exp.push_back(a_src.pop_front());
                a_acc_beats++;
            end
            if (b_in_valid && b_in_ready) begin
                b_exp.push_back(b_src.pop_front());
                b_acc_beats++;
            end
            if (a_out_valid && a_out_ready) begin
                if (a_exp.size() == 0) begin
                    dchk(1'b0, "R5", "extra A row", CRW'(a_out_data), '0);
                end else begin
                    dchk(a_out_data == a_exp[0], "R5", "A forward row",
                         CRW'(a_out_data), CRW'(a_exp[0]));
                    void'(a_exp.pop_front());
                end
            end
            if (b_out_valid && b_out_ready) begin
                if (b_exp.size() == 0) begin
                    dchk(1'b0, "R6", "extra B row", CRW'(b_out_data), '0);
                end else begin
                    dchk(b_out_data == b_exp[0], "R6", "B forward row",
                         CRW'(b_out_data), CRW'(b_exp[0]));
                    void'(b_exp.pop_front());
                end
            end
            if (c_out_valid && c_out_ready) begin
                // R2 packing and R3 arithmetic checked per result row
                if (c_exp.size() == 0) begin
                    dchk(1'b0, "R3", "extra result row", c_out_data, '0);
                end else begin
                    dchk(c_out_data == c_exp[0], "R3", "result row",
                         c_out_data, c_exp[0]);
                    void'(c_exp.pop_front());
                end
                dchk(c_out_last == (c_row_idx == N - 1), "R7", "last flag",
                     CRW'(c_out_last), CRW'(c_row_idx == N - 1));
                c_row_idx = (c_row_idx == N - 1) ? 0 : c_row_idx + 1;
                c_seen++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks + drv_checks + 1,
                     errors + drv_errors + 1);
            $finish;
        end
    end

    // Queue one product of random tiles and its expected result rows.
    task automatic push_product(input int tc);
        int a [N][N];
        int b [N][N];
        int c [N][N];
        int np;
        byte v;
        logic [ORW-1:0] row;
        logic [CRW-1:0] crow;
        np = (tc == 0) ? 1 : tc;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) c[i][j] = 0;
        for (int p = 0; p < np; p++) begin
            for (int i = 0; i < N; i++) begin
                for (int k = 0; k < N; k++) begin
                    v = byte'($urandom_range(255)); a[i][k] = v;
                    v = byte'($urandom_range(255)); b[i][k] = v;
                end
            end
            for (int i = 0; i < N; i++) begin
                row = '0;
                for (int k = 0; k < N; k++) row[k*DW +: DW] = DW'(a[i][k]);
                a_src.push_back(row);
                row = '0;
                for (int k = 0; k < N; k++) row[k*DW +: DW] = DW'(b[i][k]);
                b_src.push_back(row);
            end
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    for (int k = 0; k < N; k++)
                        c[i][j] = c[i][j] + a[i][k] * b[k][j];
        end
        for (int i = 0; i < N; i++) begin
            crow = '0;
            for (int j = 0; j < N; j++) crow[j*AW +: AW] = AW'(c[i][j]);
            c_exp.push_back(crow);
        end
    endtask

    // Wait for every queue to empty, then confirm nothing extra appears.
    task automatic wait_drain(input string req);
        while (a_src.size() + b_src.size() + a_exp.size() + b_exp.size()
               + c_exp.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
        #1;
        chk(!a_out_valid && !b_out_valid && !c_out_valid, req,
            "idle after drain", CRW'({a_out_valid, b_out_valid, c_out_valid}), '0);
    endtask

    initial begin
        int a_base, b_base, c_base;
        repeat (3) @(negedge clk);
        #1;
        chk(!a_out_valid && !b_out_valid && !c_out_valid, "R1", "valids in reset",
            CRW'({a_out_valid, b_out_valid, c_out_valid}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!a_out_valid, "R1", "a_out_valid", CRW'(a_out_valid), '0);
        chk(!b_out_valid, "R1", "b_out_valid", CRW'(b_out_valid), '0);
        chk(!c_out_valid, "R1", "c_out_valid", CRW'(c_out_valid), '0);
        chk(a_in_ready && b_in_ready, "R1", "input readies",
            CRW'({a_in_ready, b_in_ready}), CRW'(2'b11));

        // R8 / R10: forwarding blocked, only two tiles fit per side.
        tile_cnt = CW'(1);
        rdy_a_pct = 0; rdy_b_pct = 0; rdy_c_pct = 100; val_pct = 100;
        a_base = a_acc_beats; b_base = b_acc_beats; c_base = c_seen;
        for (int p = 0; p < 3; p++) push_product(1);
        repeat (300) @(negedge clk);
        #1;
        chk(a_acc_beats - a_base == 2 * N, "R8", "A beats taken",
            CRW'(a_acc_beats - a_base), CRW'(2 * N));
        chk(b_acc_beats - b_base == 2 * N, "R8", "B beats taken",
            CRW'(b_acc_beats - b_base), CRW'(2 * N));
        chk(!a_in_ready && !b_in_ready, "R10", "banks kept until forwarded",
            CRW'({a_in_ready, b_in_ready}), '0);
        chk(c_seen - c_base == 2 * N, "R10", "both held pairs multiplied",
            CRW'(c_seen - c_base), CRW'(2 * N));
        rdy_a_pct = 60; rdy_b_pct = 60;
        wait_drain("R10");

        // Single-pair products under random backpressure.
        rdy_a_pct = 70; rdy_b_pct = 50; rdy_c_pct = 60; val_pct = 70;
        for (int p = 0; p < 4; p++) push_product(1);
        wait_drain("R3");

        // Multi-pair reduction (R4).
        tile_cnt = CW'(3);
        for (int p = 0; p < 3; p++) push_product(3);
        wait_drain("R4");

        // Zero count behaves as one pair (R4).
        tile_cnt = CW'(0);
        for (int p = 0; p < 2; p++) push_product(0);
        wait_drain("R4");

        // Heavy backpressure on every output.
        tile_cnt = CW'(2);
        rdy_a_pct = 20; rdy_b_pct = 25; rdy_c_pct = 15; val_pct = 50;
        for (int p = 0; p < 2; p++) push_product(2);
        wait_drain("R6");

        // R9: result drain blocked while further products arrive.
        tile_cnt = CW'(1);
        rdy_a_pct = 100; rdy_b_pct = 100; rdy_c_pct = 0; val_pct = 100;
        a_base = a_acc_beats; c_base = c_seen;
        for (int p = 0; p < 5; p++) push_product(1);
        repeat (400) @(negedge clk);
        #1;
        chk(c_out_valid, "R9", "held result offered", CRW'(c_out_valid), CRW'(1));
        chk(c_out_data == c_exp[0], "R9", "held first row", c_out_data, c_exp[0]);
        chk(!c_out_last, "R9", "held row is row 0", CRW'(c_out_last), '0);
        chk(a_acc_beats - a_base == 4 * N, "R9", "A beats while stalled",
            CRW'(a_acc_beats - a_base), CRW'(4 * N));
        chk(c_seen == c_base, "R9", "no rows while blocked",
            CRW'(c_seen - c_base), '0);
        rdy_c_pct = 100;
        wait_drain("R9");

        $display("CHECKS %0d ERRORS %0d", checks + drv_checks, errors + drv_errors);
        $finish;
    end
endmodule